// File: doc/BRIEF.md
# Link bring-up sequencer

This block powers up the reference PLL of a serial link and then releases the link's resets in a fixed order, timing every step in hardware. A single start pulse launches the run. The block first holds the PLL powered down and bypassed. It then takes the PLL out of power-down and out of bypass. Next it asserts the local PHY and core resets and drives the attached device's reset low, holds that state, and releases the local resets, PHY first. Only then does it raise the training enable. The last step releases the remote reset, after which a long settle period follows.

All waits are counted by one down-counter that is reloaded on every step. Each wait is given in microseconds and scaled by a clocks-per-microsecond parameter, so a bench can shrink every time without touching the order. When the settle period ends, the block samples a link-detect input. It reports whether a device answered and raises done, which stays high until the next start.

Top module: `link_bringup_seq`

## Requirements
- R1: A synchronous reset drives the safe state: pll_pwrdn_o=1, pll_bypass_o=1, phy_rst_o=1, core_rst_o=1, remote_rst_n_o=0, train_en_o=0, done_o=0, absent_o=0. The block keeps this state until start_i is seen high at a clock edge.
- R2: A start seen at an edge while idle sets pll_pwrdn_o and pll_bypass_o and clears train_en_o, done_o and absent_o at that same edge. This PLL hold lasts PLL_HOLD_US*CLK_PER_US cycles.
- R3: pll_pwrdn_o falls first and is followed by a wait of STEP_US*CLK_PER_US cycles. pll_bypass_o then falls and is followed by the same wait. Bypass is never released while power-down is still set.
- R4: phy_rst_o then rises, followed by RST_US*CLK_PER_US cycles. core_rst_o then rises, followed by the same wait.
- R5: remote_rst_n_o then goes low and stays low for REMOTE_US*CLK_PER_US cycles. Both local resets stay asserted for that whole time.
- R6: phy_rst_o falls and is followed by RST_US*CLK_PER_US cycles. core_rst_o then falls and is followed by the same wait. Only then does train_en_o rise. train_en_o is never high while either local reset is set.
- R7: One cycle after train_en_o rises, remote_rst_n_o goes high, and REMOTE_US*CLK_PER_US settle cycles follow. done_o then rises and stays high until the next start.
- R8: At the edge where done_o rises, absent_o takes the inverse of link_detect_i sampled at that edge. A detect of 0 does not stop done_o from rising.
- R9: A start pulse that arrives while a run is in progress is ignored, and the run keeps its timing.
- R10: A synchronous reset in the middle of a run returns all outputs to the R1 safe state at that edge, and the aborted run does not resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launches a bring-up run when idle |
| link_detect_i | input | 1 | Device presence, sampled at the end of the settle period |
| pll_pwrdn_o | output | 1 | PLL power-down, active high |
| pll_bypass_o | output | 1 | PLL bypass, active high |
| phy_rst_o | output | 1 | Local PHY reset, active high |
| core_rst_o | output | 1 | Local link core reset, active high |
| remote_rst_n_o | output | 1 | Attached device reset, active low |
| train_en_o | output | 1 | Link training enable |
| done_o | output | 1 | Run complete, held until next start |
| absent_o | output | 1 | No device detected at the end of the run |

## Verification
The assertions assume that start_i and link_detect_i are synchronous to clk and that rst is held for at least one edge. They also assume that done may be dropped only by a start pulse, never by the input pins alone. The stimulus changes every input only on the falling clock edge. Runs are launched with random detect levels before and at the sampling edge, and extra start pulses land at random points inside a run, including the last cycle before completion. One run is aborted by reset at a random cycle.

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int unsigned CLK_PER_US  = 100,
  parameter int unsigned PLL_HOLD_US = 10000,
  parameter int unsigned STEP_US     = 1000,
  parameter int unsigned RST_US      = 10000,
  parameter int unsigned REMOTE_US   = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic link_detect_i,
  output logic pll_pwrdn_o,
  output logic pll_bypass_o,
  output logic phy_rst_o,
  output logic core_rst_o,
  output logic remote_rst_n_o,
  output logic train_en_o,
  output logic done_o,
  output logic absent_o
);
  localparam int unsigned C_PLL  = PLL_HOLD_US * CLK_PER_US;
  localparam int unsigned C_STEP = STEP_US * CLK_PER_US;
  localparam int unsigned C_RST  = RST_US * CLK_PER_US;
  localparam int unsigned C_REM  = REMOTE_US * CLK_PER_US;
  localparam int unsigned C_A    = (C_PLL > C_STEP) ? C_PLL : C_STEP;
  localparam int unsigned C_B    = (C_RST > C_REM) ? C_RST : C_REM;
  localparam int unsigned C_MAX  = (C_A > C_B) ? C_A : C_B;
  localparam int unsigned CW     = $clog2(C_MAX + 1);

  localparam logic [CW-1:0] L_PLL  = CW'(C_PLL - 1);
  localparam logic [CW-1:0] L_STEP = CW'(C_STEP - 1);
  localparam logic [CW-1:0] L_RST  = CW'(C_RST - 1);
  localparam logic [CW-1:0] L_REM  = CW'(C_REM - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PLL, ST_PWRUP, ST_UNBYP, ST_PHYON, ST_COREON,
    ST_REMOTE, ST_PHYOFF, ST_COREOFF, ST_TRAIN, ST_SETTLE
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  wire           expired = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      cnt            <= '0;
      pll_pwrdn_o    <= 1'b1;
      pll_bypass_o   <= 1'b1;
      phy_rst_o      <= 1'b1;
      core_rst_o     <= 1'b1;
      remote_rst_n_o <= 1'b0;
      train_en_o     <= 1'b0;
      done_o         <= 1'b0;
      absent_o       <= 1'b0;
    end else if (st == ST_IDLE) begin
      if (start_i) begin
        st           <= ST_PLL;
        cnt          <= L_PLL;
        pll_pwrdn_o  <= 1'b1;
        pll_bypass_o <= 1'b1;
        train_en_o   <= 1'b0;
        done_o       <= 1'b0;
        absent_o     <= 1'b0;
      end
    end else if (!expired) begin
      cnt <= cnt - 1'b1;
    end else begin
      unique case (st)
        ST_PLL:     begin st <= ST_PWRUP;   cnt <= L_STEP; pll_pwrdn_o    <= 1'b0; end
        ST_PWRUP:   begin st <= ST_UNBYP;   cnt <= L_STEP; pll_bypass_o   <= 1'b0; end
        ST_UNBYP:   begin st <= ST_PHYON;   cnt <= L_RST;  phy_rst_o      <= 1'b1; end
        ST_PHYON:   begin st <= ST_COREON;  cnt <= L_RST;  core_rst_o     <= 1'b1; end
        ST_COREON:  begin st <= ST_REMOTE;  cnt <= L_REM;  remote_rst_n_o <= 1'b0; end
        ST_REMOTE:  begin st <= ST_PHYOFF;  cnt <= L_RST;  phy_rst_o      <= 1'b0; end
        ST_PHYOFF:  begin st <= ST_COREOFF; cnt <= L_RST;  core_rst_o     <= 1'b0; end
        ST_COREOFF: begin st <= ST_TRAIN;   cnt <= '0;     train_en_o     <= 1'b1; end
        ST_TRAIN:   begin st <= ST_SETTLE;  cnt <= L_REM;  remote_rst_n_o <= 1'b1; end
        ST_SETTLE:  begin
          st       <= ST_IDLE;
          done_o   <= 1'b1;
          absent_o <= ~link_detect_i;
        end
        default:    st <= ST_IDLE;
      endcase
    end
  end

  a_r1_safe_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pll_pwrdn_o && pll_bypass_o && phy_rst_o && core_rst_o &&
                    !remote_rst_n_o && !train_en_o && !done_o && !absent_o));

  a_r3_bypass_after_pwrdn: assert property (@(posedge clk) disable iff (rst)
    !pll_bypass_o |-> !pll_pwrdn_o);

  a_r4_core_after_phy: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst_o) |-> phy_rst_o);

  a_r5_locals_held_in_remote: assert property (@(posedge clk) disable iff (rst)
    $fell(remote_rst_n_o) |-> (phy_rst_o && core_rst_o));

  a_r6_train_after_release: assert property (@(posedge clk) disable iff (rst)
    train_en_o |-> (!phy_rst_o && !core_rst_o));

  a_r7_remote_last: assert property (@(posedge clk) disable iff (rst)
    $rose(remote_rst_n_o) |-> train_en_o);

  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> !$rose(pll_pwrdn_o));
endmodule

// File: tb/link_bringup_seq_test.sv
module link_bringup_seq_test;
  localparam int unsigned CPU = 2;
  localparam int unsigned TP = 10, TS = 1, TR = 10, TM = 100;
  localparam int DP = TP * CPU, DS = TS * CPU, DR = TR * CPU, DM = TM * CPU;
  localparam int B1 = DP, B2 = B1 + DS, B3 = B2 + DS, B4 = B3 + DR, B5 = B4 + DR;
  localparam int B6 = B5 + DM, B7 = B6 + DR, B8 = B7 + DR, B9 = B8 + 1, B10 = B9 + DM;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, det = 1'b0;
  logic pwrdn, byp, phy, core, rn, train, done, absent;

  link_bringup_seq #(.CLK_PER_US(CPU), .PLL_HOLD_US(TP), .STEP_US(TS),
                     .RST_US(TR), .REMOTE_US(TM)) uut (
    .clk(clk), .rst(rst), .start_i(start), .link_detect_i(det),
    .pll_pwrdn_o(pwrdn), .pll_bypass_o(byp), .phy_rst_o(phy), .core_rst_o(core),
    .remote_rst_n_o(rn), .train_en_o(train), .done_o(done), .absent_o(absent));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic p_phy = 1'b1, p_core = 1'b1, p_rn = 1'b0;

  task automatic chk(string req, string name, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
    end
  endtask

  // expected {pwrdn,byp,phy,core,rn,train,done,absent} t cycles after the start edge
  function automatic logic [7:0] model(int t, logic det_end);
    logic pw, by, ph, co, r, tr, dn, ab;
    pw = (t < B1);
    by = (t < B2);
    ph = (t < B3) ? p_phy  : (t < B6);
    co = (t < B4) ? p_core : (t < B7);
    r  = (t < B5) ? p_rn   : (t >= B9);
    tr = (t >= B8);
    dn = (t >= B10);
    ab = dn && !det_end;
    return {pw, by, ph, co, r, tr, dn, ab};
  endfunction

  task automatic check_vec(logic [7:0] e, string tag);
    chk(tag == "" ? "R2" : tag, "pll_pwrdn",   pwrdn,  e[7]);
    chk(tag == "" ? "R3" : tag, "pll_bypass",  byp,    e[6]);
    chk(tag == "" ? "R4" : tag, "phy_rst",     phy,    e[5]);
    chk(tag == "" ? "R6" : tag, "core_rst",    core,   e[4]);
    chk(tag == "" ? "R5" : tag, "remote_rst_n", rn,    e[3]);
    chk(tag == "" ? "R6" : tag, "train_en",    train,  e[2]);
    chk(tag == "" ? "R7" : tag, "done",        done,   e[1]);
    chk(tag == "" ? "R8" : tag, "absent",      absent, e[0]);
  endtask

  task automatic run_seq(logic det_early, logic det_end, int glitch, int extra);
    det = det_early;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= B10 + 3 + extra; t++) begin
      check_vec(model(t, det_end), "");
      if (glitch >= 0 && t == glitch + 1)
        chk("R9", "busy start ignored", pwrdn, model(t, det_end)[7]);
      start = (t == glitch);
      det = (t >= B10 - 1) ? det_end : det_early;
      @(negedge clk);
    end
    start = 1'b0;
    p_phy = 1'b0; p_core = 1'b0; p_rn = 1'b1;
  endtask

  task automatic run_reset_mid(int t_abort);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (t_abort) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_vec(8'b1111_0000, "R10");
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_vec(8'b1111_0000, "R10");
    end
    p_phy = 1'b1; p_core = 1'b1; p_rn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_vec(8'b1111_0000, "R1");
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check_vec(8'b1111_0000, "R1");
    end
    run_seq(1'b1, 1'b1, -1, 0);
    run_seq(1'b1, 1'b0, 5, 2);
    run_seq(1'b0, 1'b1, B10 - 1, 3);
    for (int i = 0; i < 4; i++) begin
      int g;
      g = ($urandom % 3 == 0) ? -1 : int'($urandom % B10);
      run_seq(1'($urandom % 2), 1'($urandom % 2), g, int'($urandom % 6));
    end
    run_reset_mid(int'($urandom % (B10 - 2)) + 1);
    run_seq(1'($urandom % 2), 1'b0, int'($urandom % B10), 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule